// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets a host read and write a 16-entry, 4-bit register file over three wires: a chip enable `ce`, a shift clock `sclk` and one data line that is split into `sio_in`, `sio_out` and the drive enable `sio_oe`. The block runs entirely in the `sclk` domain. A low level on `ce` acts as an asynchronous frame reset. The host raises `ce` and then clocks in 8-bit command bytes. The block takes each input bit on a falling edge of `sclk` and moves its outputs on rising edges. A command byte has an ignored first bit, then three flags (read/write select, address-load, data-write), then a 4-bit address with the most significant bit first.

The controller is a three-state machine. CMD_IDLE (`ST_CMD`) collects a command byte. At the eighth falling edge it loads the address register when address-load is set and data-write is clear. It then moves to `ST_RD` on a read command, to `ST_WR` on a write command, or stays in `ST_CMD` for any other flag combination. `ST_RD` is the byte in which the line turns around and the addressed register is shifted out; at its eighth falling edge the machine returns to `ST_CMD`. `ST_WR` is the byte that carries the write data; at its eighth falling edge the machine pulses the write strobe and returns to `ST_CMD`. When `ce` goes low the machine is forced to `ST_CMD` at once from any state. Frames chain back to back for as long as `ce` stays high.

Top module: `three_wire_slave`

## Requirements
- R1: While `ce` is low, `sio_oe` and `reg_we` are 0. The first falling edge of `sclk` after `ce` rises takes bit 1 of a new command byte.
- R2: Input bits are taken on falling edges of `sclk`. `sio_out` and `sio_oe` change only on rising edges of `sclk`, apart from the release caused by `ce` going low.
- R3: A command byte lasts 8 clocks. Bit 1 is ignored whatever its value. Bits 2, 3 and 4 are R/W, AD and DT. Bits 5 to 8 are address bits A3 down to A0.
- R4: The address register loads A3..A0 only when AD=1 and DT=0. Every other combination leaves it unchanged, and `ce` going low does not clear it. `reg_addr` always shows this register.
- R5: A write command (R/W=0, AD=0, DT=1) takes data bits D3..D0 from clocks 5 to 8 of the next byte, MSB first. `reg_we` is then high for exactly one `sclk` period, starting at the eighth falling edge, with `reg_addr` set to the address register and `reg_wdata` set to the data.
- R6: After a read command (R/W=1, AD=1, DT=0), `sio_oe` rises at the rising edge of clock 2 of the next byte.
- R7: In that byte, `sio_out` carries bits 3, 2, 1 and 0 of `reg_rdata`, each starting at the rising edge of clocks 5, 6, 7 and 8 in turn.
- R8: `sio_oe` falls at the rising edge of clock 1 of the byte after the read byte. That clock is bit 1 of a new command byte.
- R9: While `ce` stays high, frames follow each other with no gap, and a write frame may come directly after a read.
- R10: If `ce` falls in the middle of a frame, `sio_oe` drops at once, the frame is abandoned and no write occurs.
- R11: A command byte with any other flag combination causes no write and no output drive. The byte after it is taken as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ce | input | 1 | Chip enable; low level resets the frame asynchronously |
| sclk | input | 1 | Shift clock from the host |
| sio_in | input | 1 | Serial data from the host, taken on falling edges |
| sio_out | output | 1 | Serial read data to the host, changes on rising edges |
| sio_oe | output | 1 | High while the slave drives the data line |
| reg_addr | output | 4 | Address register, presented to the register file |
| reg_wdata | output | 4 | Data for a register-file write |
| reg_we | output | 1 | Register-file write strobe, one `sclk` period |
| reg_rdata | input | 4 | Contents of the register at `reg_addr` |

## Verification
The checker counts rising and falling edges since `ce` rose and compares each byte boundary against these counts. It therefore assumes that the host never stops `sclk` partway through a byte while `ce` stays high, and that `ce` only changes while `sclk` is low. It also assumes `reg_rdata` is a settled function of `reg_addr` at each rising edge. The bench meets these conditions by running `sclk` all the time, moving `ce` just after a falling edge, and modelling the register file as a plain array read through `reg_addr` and written on the rising edge that sees `reg_we`.

// File: rtl/tws_pkg.sv
package tws_pkg;

    // Byte-level phase of the serial controller.
    typedef enum logic [1:0] {
        ST_CMD = 2'd0,   // collecting a command byte
        ST_RD  = 2'd1,   // turnaround and read-data byte
        ST_WR  = 2'd2    // write-data byte
    } tws_state_e;

    // Fixed part of a command byte: ignored bit plus three flags.
    localparam int CTRL_BITS = 4;

endpackage

// File: rtl/tws_rx.sv
module tws_rx
    import tws_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int FL    = CTRL_BITS + ADDR_W,
    localparam int CW    = $clog2(FL)
) (
    input  logic          sclk,
    input  logic          ce,
    input  logic          sio_in,
    output logic [CW-1:0] bit_cnt,
    output logic          last_bit,
    output logic [FL-2:0] word
);

    localparam logic [CW-1:0] LAST = CW'(FL - 1);

    logic [FL-3:0] shreg;

    // Falling-edge sampler: bit position in the byte and the bits seen so far.
    always_ff @(negedge sclk or negedge ce) begin
        if (!ce) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
            shreg   <= {shreg[FL-4:0], sio_in};
        end
    end

    // The byte as it stands including the bit on the line at this edge,
    // minus its ignored first bit.
    assign word     = {shreg, sio_in};
    assign last_bit = (bit_cnt == LAST);

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int FL    = CTRL_BITS + ADDR_W
) (
    input  logic              sclk,
    input  logic              ce,
    input  logic              last_bit,
    input  logic [FL-2:0]     word,
    output logic              in_read,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata
);

    tws_state_e        state_q, state_d;
    logic              f_rw, f_ad, f_dt;
    logic              is_rd, is_wr;
    logic              ld_addr, fire_we;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        f_rw    = word[FL-2];
        f_ad    = word[FL-3];
        f_dt    = word[FL-4];
        is_rd   = f_rw && f_ad && !f_dt;
        is_wr   = f_dt && !f_rw && !f_ad;
        ld_addr = 1'b0;
        fire_we = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_CMD: if (last_bit) begin
                ld_addr = f_ad && !f_dt;
                if (is_rd)      state_d = ST_RD;
                else if (is_wr) state_d = ST_WR;
                else            state_d = ST_CMD;
            end
            ST_RD: if (last_bit) state_d = ST_CMD;
            ST_WR: if (last_bit) begin
                fire_we = 1'b1;
                state_d = ST_CMD;
            end
            default: state_d = ST_CMD;
        endcase
    end

    // State register: chip enable low forces a fresh command byte.
    always_ff @(negedge sclk or negedge ce) begin
        if (!ce) state_q <= ST_CMD;
        else     state_q <= state_d;
    end

    // Registered outputs of the state machine.
    always_ff @(negedge sclk or negedge ce) begin
        if (!ce) begin
            we    <= 1'b0;
            wdata <= '0;
        end else begin
            we <= fire_we;
            if (fire_we) wdata <= word[DATA_W-1:0];
        end
    end

    // Address register survives chip enable going low.
    always_ff @(negedge sclk) begin
        if (ld_addr) addr_q <= word[ADDR_W-1:0];
    end

    assign addr    = addr_q;
    assign in_read = (state_q == ST_RD);

endmodule

// File: rtl/tws_tx.sv
module tws_tx
    import tws_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4,
    localparam int FL    = CTRL_BITS + ADDR_W,
    localparam int CW    = $clog2(FL)
) (
    input  logic              sclk,
    input  logic              ce,
    input  logic              in_read,
    input  logic [CW-1:0]     bit_cnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              sio_out,
    output logic              sio_oe
);

    // bit_cnt at a rising edge equals that clock's number minus one.
    localparam logic [CW-1:0] LOAD_AT = CW'(FL - DATA_W);

    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge sclk or negedge ce) begin
        if (!ce) begin
            sio_oe  <= 1'b0;
            sio_out <= 1'b0;
            tx_sh   <= '0;
        end else begin
            sio_oe <= in_read && (bit_cnt != '0);
            if (in_read && bit_cnt == LOAD_AT) begin
                sio_out <= rdata[DATA_W-1];
                tx_sh   <= rdata << 1;
            end else if (in_read && bit_cnt > LOAD_AT) begin
                sio_out <= tx_sh[DATA_W-1];
                tx_sh   <= tx_sh << 1;
            end else begin
                sio_out <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/three_wire_slave.sv
module three_wire_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              ce,
    input  logic              sclk,
    input  logic              sio_in,
    output logic              sio_out,
    output logic              sio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int FL = CTRL_BITS + ADDR_W;
    localparam int CW = $clog2(FL);

    logic [CW-1:0] bit_cnt;
    logic          last_bit;
    logic [FL-2:0] word;
    logic          in_read;

    tws_rx #(.ADDR_W(ADDR_W)) u_rx (
        .sclk     (sclk),
        .ce       (ce),
        .sio_in   (sio_in),
        .bit_cnt  (bit_cnt),
        .last_bit (last_bit),
        .word     (word)
    );

    tws_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .sclk     (sclk),
        .ce       (ce),
        .last_bit (last_bit),
        .word     (word),
        .in_read  (in_read),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata)
    );

    tws_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
        .sclk     (sclk),
        .ce       (ce),
        .in_read  (in_read),
        .bit_cnt  (bit_cnt),
        .rdata    (reg_rdata),
        .sio_out  (sio_out),
        .sio_oe   (sio_oe)
    );

endmodule

// File: rtl/tws_checker.sv
module tws_checker
    import tws_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int FL    = CTRL_BITS + ADDR_W,
    localparam int CW    = $clog2(FL)
) (
    input logic ce,
    input logic sclk,
    input logic sio_oe,
    input logic reg_we
);

    localparam logic [CW-1:0] OE_ON_SEEN  = CW'(2);
    localparam logic [CW-1:0] OE_OFF_SEEN = CW'(1);

    // Edge counters since chip enable rose, independent of the design.
    logic [CW-1:0] pos_cnt, neg_cnt;
    logic          oe_d, we_d;

    always_ff @(posedge sclk or negedge ce) begin
        if (!ce) begin
            pos_cnt <= '0;
            oe_d    <= 1'b0;
        end else begin
            pos_cnt <= pos_cnt + 1'b1;
            oe_d    <= sio_oe;
        end
    end

    always_ff @(negedge sclk or negedge ce) begin
        if (!ce) begin
            neg_cnt <= '0;
            we_d    <= 1'b0;
        end else begin
            neg_cnt <= neg_cnt + 1'b1;
            we_d    <= reg_we;
        end
    end

    AST_OE_RISE_CLK2: assert property (@(posedge sclk) disable iff (!ce)
        (!oe_d && sio_oe) |-> (pos_cnt == OE_ON_SEEN)); // R6

    AST_OE_FALL_CLK1: assert property (@(posedge sclk) disable iff (!ce)
        (oe_d && !sio_oe) |-> (pos_cnt == OE_OFF_SEEN)); // R8

    AST_WE_SINGLE_PULSE: assert property (@(negedge sclk) disable iff (!ce)
        we_d |-> !reg_we); // R5

    AST_WE_AT_BYTE_END: assert property (@(negedge sclk) disable iff (!ce)
        (!we_d && reg_we) |-> (neg_cnt == '0)); // R5

    AST_NO_WE_WHILE_DRIVE: assert property (@(posedge sclk) disable iff (!ce)
        sio_oe |-> !reg_we); // R9

endmodule

bind three_wire_slave tws_checker #(.ADDR_W(ADDR_W)) u_chk (
    .ce     (ce),
    .sclk   (sclk),
    .sio_oe (sio_oe),
    .reg_we (reg_we)
);

// File: tb/sim_three_wire_slave.sv
`timescale 1ns/1ps
module sim_three_wire_slave;

    logic       ce = 1'b0;
    logic       sclk = 1'b0;
    logic       sio_in = 1'b0;
    logic       sio_out, sio_oe, reg_we;
    logic [3:0] reg_addr, reg_wdata, reg_rdata;

    int checks = 0;
    int failures = 0;
    string tag = "";

    always #5 sclk = ~sclk;   // 100 MHz

    three_wire_slave u0 (
        .ce(ce), .sclk(sclk), .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Register file seen by the slave.
    logic [3:0] rf [16];
    assign reg_rdata = rf[reg_addr];
    always @(posedge sclk) if (reg_we) rf[reg_addr] <= reg_wdata;

    // Reference model: 0 command byte, 1 read byte, 2 write byte.
    int         m_kind = 0;
    int         m_pos = 0;
    logic [7:0] m_bits = '0;
    logic [3:0] m_addr = '0;
    logic [3:0] m_mem [16];
    logic       m_pend = 1'b0;
    logic [3:0] m_wa = '0, m_wd = '0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, tag, act, exp, $time);
        end
    endtask

    task automatic clk_cycle(input logic din);
        logic e_oe, oe_now, out_now;
        @(posedge sclk);
        #2;
        e_oe = (m_kind == 1) && (m_pos >= 1);
        if (m_kind == 1)      chk("R6", {7'd0, sio_oe}, {7'd0, e_oe});
        else if (m_kind == 2) chk("R5", {7'd0, sio_oe}, 8'd0);
        else                  chk("R8/R11", {7'd0, sio_oe}, 8'd0);
        if (m_kind == 1 && m_pos >= 4)
            chk("R7", {7'd0, sio_out}, {7'd0, m_mem[m_addr][7-m_pos]});
        chk("R5", {7'd0, reg_we}, {7'd0, m_pend});
        if (m_pend) begin
            chk("R4", {4'd0, reg_addr}, {4'd0, m_wa});
            chk("R5", {4'd0, reg_wdata}, {4'd0, m_wd});
        end
        m_pend = 1'b0;
        oe_now = sio_oe;
        out_now = sio_out;
        #1 sio_in = din;
        m_bits = {m_bits[6:0], din};
        m_pos++;
        if (m_pos == 8) begin
            m_pos = 0;
            if (m_kind == 0) begin
                if (m_bits[5] && !m_bits[4]) m_addr = m_bits[3:0];
                if (m_bits[6] && m_bits[5] && !m_bits[4])      m_kind = 1;
                else if (m_bits[4] && !m_bits[6] && !m_bits[5]) m_kind = 2;
                else                                            m_kind = 0;
            end else if (m_kind == 2) begin
                m_mem[m_addr] = m_bits[3:0];
                m_pend = 1'b1;
                m_wa = m_addr;
                m_wd = m_bits[3:0];
                m_kind = 0;
            end else begin
                m_kind = 0;
            end
        end
        // Outputs hold through the falling edge.
        @(negedge sclk);
        #1;
        chk("R2", {6'd0, sio_oe, sio_out}, {6'd0, oe_now, out_now});
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) clk_cycle(b[i]);
    endtask

    task automatic ce_on();
        @(negedge sclk);
        #1 ce = 1'b1;
        m_kind = 0;
        m_pos = 0;
        m_pend = 1'b0;
    endtask

    task automatic ce_off();
        ce = 1'b0;
        #1;
        chk("R10", {7'd0, sio_oe}, 8'd0);
        chk("R1", {7'd0, reg_we}, 8'd0);
        m_kind = 0;
        m_pos = 0;
        m_pend = 1'b0;
    endtask

    // Command byte: ignored bit, R/W, AD, DT, A3..A0.
    function automatic logic [7:0] cmd(input logic ign, input logic rw, input logic ad,
                                       input logic dt, input logic [3:0] a);
        return {ign, rw, ad, dt, a};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired R1 actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf[i] = 4'(i ^ 5);
            m_mem[i] = 4'(i ^ 5);
        end
        #22;
        tag = "reset";
        chk("R1", {7'd0, sio_oe}, 8'd0);
        chk("R1", {7'd0, reg_we}, 8'd0);
        repeat (3) @(negedge sclk);
        #1;
        chk("R1", {7'd0, sio_oe}, 8'd0);

        // Read addr 3 with first bit 0, then a write chained directly (R3, R9).
        ce_on();
        tag = "R9 read-then-write";
        send_byte(cmd(1'b0, 1'b1, 1'b1, 1'b0, 4'd3));
        send_byte(8'hA5);
        send_byte(cmd(1'b1, 1'b0, 1'b0, 1'b1, 4'hF));
        send_byte(8'h39);
        // Read back addr 3 with first bit 1 (R3).
        tag = "R3 ignored bit";
        send_byte(cmd(1'b1, 1'b1, 1'b1, 1'b0, 4'd3));
        send_byte(8'h00);

        // Address load only (R4), a no-op with AD=DT=1 (R11), then a write.
        tag = "R4 address only";
        send_byte(cmd(1'b0, 1'b0, 1'b1, 1'b0, 4'd7));
        send_byte(cmd(1'b0, 1'b0, 1'b1, 1'b1, 4'd12));
        send_byte(cmd(1'b0, 1'b0, 1'b0, 1'b1, 4'd0));
        send_byte(8'hFC);
        // R/W=1 with AD=0 is a no-op (R11); then read addr 7.
        tag = "R11 other flags";
        send_byte(cmd(1'b0, 1'b1, 1'b0, 1'b0, 4'd5));
        send_byte(cmd(1'b0, 1'b1, 1'b1, 1'b0, 4'd7));
        send_byte(8'hFF);

        // Drop ce in the middle of a write byte (R10).
        tag = "R10 abort write";
        send_byte(cmd(1'b0, 1'b0, 1'b0, 1'b1, 4'd0));
        for (int i = 7; i >= 3; i--) clk_cycle(i[0]);
        ce_off();
        // Drop ce while the line is driven (R10).
        ce_on();
        send_byte(cmd(1'b0, 1'b1, 1'b1, 1'b0, 4'd2));
        for (int i = 0; i < 6; i++) clk_cycle(1'b0);
        chk("R6", {7'd0, sio_oe}, 8'd1);
        ce_off();
        // Address survives ce low: write goes to address 2 (R4, R1).
        ce_on();
        tag = "R4 keep across ce";
        send_byte(cmd(1'b0, 1'b0, 1'b0, 1'b1, 4'd9));
        send_byte(8'h05);
        send_byte(cmd(1'b0, 1'b1, 1'b1, 1'b0, 4'd7));
        send_byte(8'h00);
        send_byte(cmd(1'b0, 1'b1, 1'b1, 1'b0, 4'd2));
        send_byte(8'h00);

        // Every address: load, write, read back (R5, R7).
        tag = "R5 sweep";
        for (int a = 0; a < 16; a++) begin
            send_byte(cmd(1'b0, 1'b0, 1'b1, 1'b0, 4'(a)));
            send_byte(cmd(1'b1, 1'b0, 1'b0, 1'b1, 4'(15 - a)));
            send_byte({4'hA, 4'(a * 7 + 3)});
        end
        tag = "R7 sweep";
        for (int a = 0; a < 16; a++) begin
            send_byte(cmd(a[0], 1'b1, 1'b1, 1'b0, 4'(a)));
            send_byte(8'h5A);
        end
        clk_cycle(1'b0);
        ce_off();
        finish_run();
    end

endmodule